// File: doc/BRIEF.md
# Register-Bus Memory Window Bridge

This block sits on a simple register-bus slave port and forwards every access that lands inside one contiguous address window to an external memory. The bus side presents a byte address, write data, byte enables and separate read-valid and write-valid strobes. It gets back read data, a ready flag and an error flag.

The block checks whether the address is inside the window. It turns the byte address into a word index counted from the window start. Accesses that hit the window start a read or write request toward the memory. The request stays up until the memory answers. The memory's answer is folded into a range-decoded read multiplexer. Any address outside the window lands in a default entry, which completes at once with an error, so a stray access cannot stall the bus.

The access mode is a parameter: read-write, read-only or write-only. A write-only window returns a constant fill word as data. The memory word width must be a power of two and at least one byte, and other widths stop elaboration. The memory storage itself is outside the block.

Top module: `memwin_bridge`

## Requirements
- R1: The word index `mem_idx` equals (bus address minus `BASE`) divided by the bytes per memory word (4 by default), truncated toward zero, so byte address 0x1FF gives index 63.
- R2: An access selects the window only when `BASE` <= address < `BASE` + `DEPTH` * bytes-per-word (0x100 to 0x1FF by default). Outside that range no memory request is ever raised.
- R3: A request (`mem_rreq` for reads, `mem_wreq` for writes) rises on the first clock edge at which the matching valid strobe is high with an address in the window.
- R4: A request stays high until the clock edge at which its acknowledge is sampled high, and drops on that edge. It is not raised again while the bus keeps the same valid strobe high. A new access needs the strobe to go low first.
- R5: While a request is outstanding, `mem_idx`, `mem_wdata` and `mem_wmask` hold the values captured when the request rose, whatever the bus address or data do.
- R6: `mem_wdata` is the bus write data unchanged. `mem_wmask` bit 8*b+k is high exactly when byte enable bit b is high (k = 0..7).
- R7: For an access in the window in read-write mode, `bus_rdy` equals `mem_rack` OR `mem_wack`.
- R8: For an access in the window, `bus_err` equals (`mem_rerr` AND `mem_rack`) OR (`mem_werr` AND `mem_wack`). An error flag shown without its acknowledge has no effect.
- R9: For an access in the window, `bus_rdata` equals `mem_rdata`. Byte enables have no effect on the data a read returns.
- R10: For an address outside the window, `bus_rdy` and `bus_err` both equal read-valid OR write-valid in the same cycle, and `bus_rdata` is zero.
- R11: While reset is high, both requests are low and `bus_rdy` is low, even with a valid strobe high on a window address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_be | input | DATA_W/8 | Bus byte enables, used on writes only |
| bus_rvld | input | 1 | Bus read strobe, held until ready |
| bus_wvld | input | 1 | Bus write strobe, held until ready |
| bus_rdata | output | DATA_W | Read data returned to the bus |
| bus_rdy | output | 1 | Access complete |
| bus_err | output | 1 | Access completed with error |
| mem_idx | output | log2(DEPTH)+1 | Word index inside the window |
| mem_rreq | output | 1 | Read request to the memory |
| mem_rdata | input | DATA_W | Read data from the memory |
| mem_rack | input | 1 | Read acknowledge, held until the request drops |
| mem_rerr | input | 1 | Read error, valid while the acknowledge is high |
| mem_wreq | output | 1 | Write request to the memory |
| mem_wdata | output | DATA_W | Write data to the memory |
| mem_wmask | output | DATA_W | Bit mask of bits the memory may change |
| mem_wack | input | 1 | Write acknowledge, held until the request drops |
| mem_werr | input | 1 | Write error, valid while the acknowledge is high |

## Verification
Some properties are checked on every cycle. Requests never rise for an address outside the window, and a rising request carries the correct word index. Requests hold until acknowledged and drop on the acknowledge edge. Index, write data and mask stay frozen while a request waits. An unmapped read always gets an immediate error with zero data, and no error reaches the bus without an acknowledge. Only the bench scenarios can show the end-to-end results: data written through partial byte masks reads back correctly, reads ignore their byte enables, the request is not reissued while the strobe is held after completion, and reset keeps everything quiet.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    // Software access mode of the window
    typedef enum logic [1:0] {
        ACC_RW = 2'd0,
        ACC_RO = 2'd1,
        ACC_WO = 2'd2
    } access_e;

    // Per-direction handshake state
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_PEND = 2'd1,
        HS_DONE = 2'd2
    } hs_state_e;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/memwin_decode.sv
module memwin_decode #(
    parameter int                ADDR_W = 16,
    parameter int                BYTES  = 4,
    parameter int                DEPTH  = 64,
    parameter int                IDX_W  = 7,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int              SHIFT = $clog2(BYTES);
    localparam logic [ADDR_W:0] LO    = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI    = {1'b0, BASE} + (ADDR_W+1)'(DEPTH * BYTES);

    logic [ADDR_W:0]   addr_x;
    logic [ADDR_W-1:0] offset;

    assign addr_x = {1'b0, addr};
    assign hit    = (addr_x >= LO) && (addr_x < HI);
    assign offset = addr - BASE;
    assign idx    = IDX_W'(offset >> SHIFT);
endmodule

// File: rtl/memwin_port.sv
module memwin_port
    import memwin_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          vld,
    input  logic          ack,
    input  logic [PW-1:0] pin,
    output logic          req,
    output logic [PW-1:0] pout
);
    hs_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            pout  <= '0;
        end else begin
            case (state)
                HS_IDLE: if (start) begin
                    state <= HS_PEND;
                    pout  <= pin;
                end
                HS_PEND: if (ack) state <= HS_DONE;
                HS_DONE: if (!vld) state <= HS_IDLE;
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign req = (state == HS_PEND);
endmodule

// File: rtl/memwin_mux.sv
module memwin_mux
    import memwin_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W-1:0] LAST   = '1,
    parameter access_e           MODE   = ACC_RW,
    parameter logic [DATA_W-1:0] FILL   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rvld,
    input  logic              wvld,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rack,
    input  logic              rerr,
    input  logic              wack,
    input  logic              werr,
    output logic [DATA_W-1:0] out_data,
    output logic              out_rdy,
    output logic              out_err
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              err;
    } resp_t;

    resp_t win, sel;

    generate
        if (MODE == ACC_RW) begin : g_rw
            always_comb begin
                win.data = rdata;
                win.rdy  = rack | wack;
                win.err  = (rerr & rack) | (werr & wack);
            end
        end else if (MODE == ACC_RO) begin : g_ro
            always_comb begin
                win.data = rdata;
                win.rdy  = rack;
                win.err  = rerr & rack;
            end
        end else begin : g_wo
            always_comb begin
                win.data = FILL;
                win.rdy  = wack;
                win.err  = werr & wack;
            end
        end
    endgenerate

    always_comb begin
        case (addr) inside
            [BASE:LAST]: sel = win;
            default: begin
                sel.data = '0;
                sel.rdy  = rvld | wvld;
                sel.err  = rvld | wvld;
            end
        endcase
    end

    assign out_data = sel.data;
    assign out_rdy  = sel.rdy;
    assign out_err  = sel.err;
endmodule

// File: rtl/memwin_bridge.sv
module memwin_bridge
    import memwin_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 32,
    parameter int                DEPTH  = 64,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0100,
    parameter access_e           MODE   = ACC_RW,
    parameter logic [DATA_W-1:0] FILL   = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic [DATA_W/8-1:0]      bus_be,
    input  logic                     bus_rvld,
    input  logic                     bus_wvld,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_rdy,
    output logic                     bus_err,
    output logic [$clog2(DEPTH):0]   mem_idx,
    output logic                     mem_rreq,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_rack,
    input  logic                     mem_rerr,
    output logic                     mem_wreq,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic [DATA_W-1:0]        mem_wmask,
    input  logic                     mem_wack,
    input  logic                     mem_werr
);
    localparam int                BYTES = DATA_W / 8;
    localparam int                IDX_W = $clog2(DEPTH) + 1;
    localparam logic [ADDR_W-1:0] LAST  = BASE + ADDR_W'(DEPTH * BYTES - 1);

    generate
        if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_width
            $error("memory word width must be a power of two of at least 8 bits");
        end
    endgenerate

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
    } wr_pl_t;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  r_idx;
    logic [DATA_W-1:0] bit_mask;
    wr_pl_t            w_in, w_out;

    memwin_decode #(
        .ADDR_W(ADDR_W), .BYTES(BYTES), .DEPTH(DEPTH), .IDX_W(IDX_W), .BASE(BASE)
    ) u_dec (
        .addr(bus_addr), .hit(hit), .idx(hit_idx)
    );

    // byte enables widened to one mask bit per data bit
    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            assign bit_mask[8*b +: 8] = {8{bus_be[b]}};
        end
    endgenerate

    assign w_in.idx  = hit_idx;
    assign w_in.data = bus_wdata;
    assign w_in.mask = bit_mask;

    generate
        if (MODE != ACC_WO) begin : g_rd
            memwin_port #(.PW(IDX_W)) u_rd (
                .clk(clk), .rst(rst),
                .start(hit && bus_rvld), .vld(bus_rvld), .ack(mem_rack),
                .pin(hit_idx), .req(mem_rreq), .pout(r_idx)
            );
        end else begin : g_no_rd
            assign mem_rreq = 1'b0;
            assign r_idx    = '0;
        end

        if (MODE != ACC_RO) begin : g_wr
            memwin_port #(.PW($bits(wr_pl_t))) u_wr (
                .clk(clk), .rst(rst),
                .start(hit && bus_wvld), .vld(bus_wvld), .ack(mem_wack),
                .pin(w_in), .req(mem_wreq), .pout(w_out)
            );
        end else begin : g_no_wr
            assign mem_wreq = 1'b0;
            assign w_out    = '0;
        end
    endgenerate

    assign mem_idx   = mem_wreq ? w_out.idx : r_idx;
    assign mem_wdata = w_out.data;
    assign mem_wmask = w_out.mask;

    memwin_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .LAST(LAST),
        .MODE(MODE), .FILL(FILL)
    ) u_mux (
        .addr(bus_addr), .rvld(bus_rvld), .wvld(bus_wvld),
        .rdata(mem_rdata), .rack(mem_rack), .rerr(mem_rerr),
        .wack(mem_wack), .werr(mem_werr),
        .out_data(bus_rdata), .out_rdy(bus_rdy), .out_err(bus_err)
    );
endmodule

// File: rtl/memwin_bridge_chk.sv
module memwin_bridge_chk #(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 32,
    parameter int                DEPTH  = 64,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0100
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_rvld,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic                   bus_rdy,
    input logic                   bus_err,
    input logic [$clog2(DEPTH):0] mem_idx,
    input logic                   mem_rreq,
    input logic                   mem_rack,
    input logic                   mem_wreq,
    input logic [DATA_W-1:0]      mem_wdata,
    input logic [DATA_W-1:0]      mem_wmask,
    input logic                   mem_wack
);
    localparam int              IDX_W = $clog2(DEPTH) + 1;
    localparam int              SH    = $clog2(DATA_W / 8);
    localparam logic [ADDR_W:0] HI    = {1'b0, BASE} + (ADDR_W+1)'(DEPTH * (DATA_W / 8));

    logic in_win;
    assign in_win = ({1'b0, bus_addr} >= {1'b0, BASE}) && ({1'b0, bus_addr} < HI);

    p_idx_map_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rreq) |-> mem_idx == IDX_W'(($past(bus_addr) - BASE) >> SH));

    p_sel_only_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_rreq) || $rose(mem_wreq)) |->
            (({1'b0, $past(bus_addr)} >= {1'b0, BASE}) && ({1'b0, $past(bus_addr)} < HI)));

    p_rhold_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rreq && !mem_rack |=> mem_rreq);

    p_whold_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wreq && !mem_wack |=> mem_wreq);

    p_rdrop_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rreq && mem_rack |=> !mem_rreq);

    p_idx_stable_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rreq && !mem_rack && !mem_wreq |=> (mem_wreq || $stable(mem_idx)));

    p_wr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wreq && !mem_wack |=> $stable(mem_wdata) && $stable(mem_wmask) && $stable(mem_idx));

    p_no_err_unacked_r8: assert property (@(posedge clk) disable iff (rst)
        in_win && !mem_rack && !mem_wack |-> !bus_err);

    p_miss_resp_r10: assert property (@(posedge clk) disable iff (rst)
        bus_rvld && !in_win |-> bus_rdy && bus_err && (bus_rdata == '0));
endmodule

bind memwin_bridge memwin_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BASE(BASE)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rvld(bus_rvld),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_err(bus_err),
    .mem_idx(mem_idx), .mem_rreq(mem_rreq), .mem_rack(mem_rack),
    .mem_wreq(mem_wreq), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_wack(mem_wack)
);

// File: tb/memwin_bridge_bench.sv
module memwin_bridge_bench;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_rvld, bus_wvld;
    logic [31:0] bus_rdata;
    logic        bus_rdy, bus_err;
    logic [6:0]  mem_idx;
    logic        mem_rreq, mem_wreq;
    logic [31:0] mem_rdata;
    logic        mem_rack, mem_wack;
    logic        mem_rerr, mem_werr;
    logic [31:0] mem_wdata, mem_wmask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    memwin_bridge u_memwin_bridge (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rvld(bus_rvld), .bus_wvld(bus_wvld),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_err(bus_err),
        .mem_idx(mem_idx), .mem_rreq(mem_rreq), .mem_rdata(mem_rdata),
        .mem_rack(mem_rack), .mem_rerr(mem_rerr),
        .mem_wreq(mem_wreq), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_wack(mem_wack), .mem_werr(mem_werr)
    );

    // external memory model: acknowledges after LAT cycles, holds ack until request drops
    logic [31:0] store [64];
    int rcnt, wcnt;
    initial for (int i = 0; i < 64; i++) store[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem_rack <= 1'b0; mem_wack <= 1'b0; rcnt <= 0; wcnt <= 0; mem_rdata <= '0;
        end else begin
            if (mem_rreq && !mem_rack) begin
                if (rcnt == LAT - 1) begin
                    mem_rack  <= 1'b1;
                    mem_rdata <= store[mem_idx[5:0]];
                    rcnt      <= 0;
                end else rcnt <= rcnt + 1;
            end else if (!mem_rreq) mem_rack <= 1'b0;
            if (mem_wreq && !mem_wack) begin
                if (wcnt == LAT - 1) begin
                    mem_wack <= 1'b1;
                    store[mem_idx[5:0]] <= (store[mem_idx[5:0]] & ~mem_wmask) | (mem_wdata & mem_wmask);
                    wcnt <= 0;
                end else wcnt <= wcnt + 1;
            end else if (!mem_wreq) mem_wack <= 1'b0;
        end
    end

    function automatic logic [31:0] expand(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input logic hit, input logic [31:0] exp,
                          input logic exp_err, input int hold);
        bit seen;
        bit got;
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_be = be;
        bus_rvld = !wr; bus_wvld = wr;
        if (!hit) begin
            #1;
            chk(bus_rdy && bus_err, "R10 unmapped rdy/err", {bus_rdy, bus_err}, 2'b11);
            chk(bus_rdata == 32'h0, "R10 unmapped data", bus_rdata, 0);
            @(negedge clk);
            chk(!mem_rreq && !mem_wreq, "R2 no request outside window", {mem_rreq, mem_wreq}, 0);
            bus_rvld = 1'b0; bus_wvld = 1'b0;
            return;
        end
        seen = 1'b0; got = 1'b0;
        for (int n = 0; n < 30 && !got; n++) begin
            @(negedge clk);
            if (!seen) begin
                seen = 1'b1;
                chk(n == 0 && (wr ? mem_wreq : mem_rreq), "R3 request launch", {mem_rreq, mem_wreq}, wr ? 1 : 2);
                chk(mem_idx == 7'((a - 16'h0100) >> 2), "R1 word index", mem_idx, 7'((a - 16'h0100) >> 2));
                if (wr) begin
                    chk(mem_wdata == wd, "R6 write data", mem_wdata, wd);
                    chk(mem_wmask == expand(be), "R6 write mask", mem_wmask, expand(be));
                end
            end
            if (bus_rdy) got = 1'b1;
            else chk(!bus_err, "R8 no error before ack", bus_err, 0);
        end
        chk(got, "R7 ready from ack", got, 1);
        if (!wr) chk(bus_rdata == exp, "R9 read data", bus_rdata, exp);
        chk(bus_err == exp_err, "R8 error at ack", bus_err, exp_err);
        chk(wr ? mem_wreq : mem_rreq, "R4 request held in ack cycle", {mem_rreq, mem_wreq}, wr ? 1 : 2);
        @(negedge clk);
        chk(!mem_rreq && !mem_wreq, "R4 request drops after ack", {mem_rreq, mem_wreq}, 0);
        repeat (hold) begin
            @(negedge clk);
            chk(!mem_rreq && !mem_wreq, "R4 no reissue while valid held", {mem_rreq, mem_wreq}, 0);
        end
        bus_rvld = 1'b0; bus_wvld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        hit;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0100, 32'hDEADBEEF, 4'hF, 1'b1, 32'h0},
        '{1'b0, 16'h0100, 32'h0,        4'hF, 1'b1, 32'hDEADBEEF},
        '{1'b1, 16'h01FC, 32'h12345678, 4'hF, 1'b1, 32'h0},
        '{1'b0, 16'h01FF, 32'h0,        4'hF, 1'b1, 32'h12345678},
        '{1'b1, 16'h0100, 32'h0000AA55, 4'h1, 1'b1, 32'h0},
        '{1'b0, 16'h0100, 32'h0,        4'h0, 1'b1, 32'hDEADBE55},
        '{1'b1, 16'h0140, 32'hCAFEF00D, 4'hA, 1'b1, 32'h0},
        '{1'b0, 16'h0140, 32'h0,        4'h3, 1'b1, 32'hCA00F000},
        '{1'b0, 16'h00FF, 32'h0,        4'hF, 1'b0, 32'h0},
        '{1'b1, 16'h0200, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0},
        '{1'b0, 16'h0000, 32'h0,        4'hF, 1'b0, 32'h0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit got;
        rst = 1'b1;
        bus_addr = 16'h0104; bus_wdata = '0; bus_be = 4'hF;
        bus_rvld = 1'b1; bus_wvld = 1'b0;
        mem_rerr = 1'b0; mem_werr = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset keeps requests and ready low
        chk(!mem_rreq && !mem_wreq, "R11 requests low in reset", {mem_rreq, mem_wreq}, 0);
        chk(!bus_rdy, "R11 ready low in reset", bus_rdy, 0);
        bus_rvld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++)
            access(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].be, VEC[i].hit, VEC[i].exp, 1'b0, 0);

        // R4: valid held after completion must not relaunch
        access(1'b0, 16'h0180, 32'h0, 4'hF, 1'b1, 32'h0, 1'b0, 4);

        // R5: bus changes while a write is outstanding
        @(negedge clk);
        bus_addr = 16'h0104; bus_wdata = 32'h11111111; bus_be = 4'hF; bus_wvld = 1'b1;
        @(negedge clk);
        bus_addr = 16'h0108; bus_wdata = 32'h22222222; bus_be = 4'h0;
        @(negedge clk);
        chk(mem_wreq && mem_idx == 7'd1, "R5 index held", mem_idx, 1);
        chk(mem_wdata == 32'h11111111 && mem_wmask == 32'hFFFFFFFF, "R5 data and mask held",
            {mem_wdata, mem_wmask}, {32'h11111111, 32'hFFFFFFFF});
        got = 1'b0;
        for (int n = 0; n < 30 && !got; n++) begin
            if (bus_rdy) got = 1'b1;
            else @(negedge clk);
        end
        chk(got, "R7 write ready", got, 1);
        bus_wvld = 1'b0;
        repeat (3) @(negedge clk);
        access(1'b0, 16'h0104, 32'h0, 4'hF, 1'b1, 32'h11111111, 1'b0, 0);
        access(1'b0, 16'h0108, 32'h0, 4'hF, 1'b1, 32'h0, 1'b0, 0);

        // R8: error flags only count together with their acknowledge
        mem_rerr = 1'b1;
        access(1'b0, 16'h0100, 32'h0, 4'hF, 1'b1, 32'hDEADBE55, 1'b1, 0);
        mem_rerr = 1'b0;
        mem_werr = 1'b1;
        access(1'b1, 16'h0110, 32'h5A5A5A5A, 4'hF, 1'b1, 32'h0, 1'b1, 0);
        mem_werr = 1'b0;
        access(1'b0, 16'h0110, 32'h0, 4'hF, 1'b1, 32'h5A5A5A5A, 1'b0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule